// File: doc/BRIEF.md
# CAN bit timing synchronizer

This block produces the bit timing of a CAN receiver. It takes a one-clock time-quantum enable from an external prescaler and divides each nominal bit into four parts, in this order: a one-quantum sync segment, a propagation segment, phase segment 1 and phase segment 2. The bus is sampled once per bit, at the end of phase segment 1. The bit value and a one-cycle sample strobe go to the frame logic downstream. A level output marks the sync quantum, which is the bit boundary.

The receive input is first passed through a two-flop synchronizer. It is then compared across successive quantum ticks to find recessive-to-dominant edges. While the bus is idle (interframe), such an edge restarts the bit at once. During reception, an edge moves the timing by a bounded amount instead: phase segment 1 is lengthened for late edges and phase segment 2 is shortened for early ones, never by more than the jump width. Segment lengths and the jump width are static configuration inputs. They may only be changed while the block is held in reset.

Top module: `can_bit_sync`

## Requirements
- R1: During and right after reset, `boundary_o` is 1, `sample_o` is 0 and `rx_bit_o` is 1 (recessive).
- R2: With no edges, every bit lasts 1 + prop + ph1 + ph2 quanta. `boundary_o` is high exactly during the sync quantum. `sample_o` is a single-cycle pulse in the cycle after the tick that ends quantum 1 + prop + ph1 of the bit.
- R3: `rx_i` passes through two clock flops. `rx_bit_o` takes the synchronized level at the sample tick and changes at no other time.
- R4: State advances only on cycles where `tq_en_i` is 1. The outputs hold between ticks.
- R5: An edge is a synchronized level of 1 at one tick followed by 0 at the next tick. If `idle_i` is 1 at the tick that detects an edge, the quantum ending at that tick is treated as the sync quantum. The next quantum starts the propagation segment, no sample is taken at that tick, and any pending adjustment is discarded, whatever the SJW setting.
- R6: During reception, an edge detected in the sync quantum causes no adjustment.
- R7: During reception, an edge detected in the k-th quantum after the sync quantum, up to and including the sample quantum, lengthens phase segment 1 of the current bit by min(k, SJW).
- R8: During reception, an edge detected in phase segment 2 with r quanta of that segment still to follow shortens phase segment 2 by min(r, SJW). If r = 0, nothing changes.
- R9: A resynchronization is attempted only when `idle_i` is 0 and the last sampled bit (`rx_bit_o`) is 1.
- R10: At most one resynchronization takes effect per bit. Later edges in the same bit are ignored.
- R11: Segment lengths go back to their configured values at the start of the next bit.
- R12: `sample_o` and `boundary_o` are never high in the same cycle. `sample_o` is never high in two consecutive cycles, and it fires at most once between bit boundaries or hard syncs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tq_en_i | input | 1 | Time-quantum tick, one clock wide |
| rx_i | input | 1 | Bus receive level, asynchronous (1 = recessive) |
| idle_i | input | 1 | Bus is in interframe space; selects hard sync |
| prop_len_i | input | 4 | Propagation segment length, 1..8 quanta |
| ph1_len_i | input | 4 | Phase segment 1 length, 1..8 quanta |
| ph2_len_i | input | 4 | Phase segment 2 length, 2..8 quanta |
| sjw_i | input | 3 | Jump width, 1..4 quanta, not above ph2 |
| sample_o | output | 1 | One-cycle strobe at the sample point |
| rx_bit_o | output | 1 | Last sampled bit value |
| boundary_o | output | 1 | High during the sync quantum of each bit |

## Verification
Some properties are checked on every cycle:
- the sample pulse is single-cycle, fires only on a tick, never overlaps the boundary and fires once per bit;
- the outputs stay still between ticks;
- the sampled bit changes only with the strobe;
- a hard sync never lands in the sync quantum.

The amount of each adjustment, its gating by the last sampled bit, the one-per-bit limit and the reversion to configured lengths depend on where the edge falls inside the bit. These are shown only by the bench. There, a quantum-indexed reference model is compared against the outputs every clock while edges are swept across all positions under several segment and jump-width settings.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;
endpackage

// File: rtl/can_bt_rx_edge.sv
module can_bt_rx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tq_en_i,
  input  logic rx_i,
  output logic rx_sync_o,
  output logic fall_o
);
  logic s1_q, s2_q, tick_lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q       <= 1'b1;
      s2_q       <= 1'b1;
      tick_lvl_q <= 1'b1;
    end else begin
      s1_q <= rx_i;
      s2_q <= s1_q;
      if (tq_en_i) tick_lvl_q <= s2_q;
    end
  end

  assign rx_sync_o = s2_q;
  // recessive at previous tick, dominant at this one
  assign fall_o    = tq_en_i & tick_lvl_q & ~s2_q;
endmodule

// File: rtl/can_bt_resync.sv
module can_bt_resync
  import can_bt_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int SJW_W = 3
) (
  input  seg_e             seg_i,
  input  logic [LEN_W:0]   cnt_i,
  input  logic [LEN_W-1:0] prop_len_i,
  input  logic [LEN_W-1:0] ph2_len_i,
  input  logic [SJW_W-1:0] sjw_i,
  input  logic [SJW_W-1:0] ext_i,
  input  logic [SJW_W-1:0] cut_i,
  input  logic             done_i,
  input  logic             try_i,
  output logic [SJW_W-1:0] ext_o,
  output logic [SJW_W-1:0] cut_o,
  output logic             done_o
);
  localparam int EW = LEN_W + 2;

  logic [EW-1:0] err;

  function automatic logic [SJW_W-1:0] clip(input logic [EW-1:0] e,
                                            input logic [SJW_W-1:0] lim);
    if (e > EW'(lim)) return lim;
    return SJW_W'(e);
  endfunction

  always_comb begin
    ext_o  = ext_i;
    cut_o  = cut_i;
    done_o = done_i;
    err    = '0;
    if (try_i && !done_i) begin
      case (seg_i)
        SEG_PROP: begin
          err    = EW'(cnt_i) + EW'(1);
          ext_o  = clip(err, sjw_i);
          done_o = 1'b1;
        end
        SEG_PH1: begin
          err    = EW'(prop_len_i) + EW'(cnt_i) + EW'(1);
          ext_o  = clip(err, sjw_i);
          done_o = 1'b1;
        end
        SEG_PH2: begin
          // quanta of phase 2 still to come after the edge quantum
          err = EW'(ph2_len_i) - EW'(cnt_i) - EW'(1);
          if (err != '0) begin
            cut_o  = clip(err, sjw_i);
            done_o = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int SJW_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tq_en_i,
  input  logic             hard_i,
  input  logic             rx_sync_i,
  input  logic [LEN_W-1:0] prop_len_i,
  input  logic [LEN_W-1:0] ph1_len_i,
  input  logic [LEN_W-1:0] ph2_len_i,
  input  logic [SJW_W-1:0] ext_n_i,
  input  logic [SJW_W-1:0] cut_n_i,
  input  logic             done_n_i,
  output seg_e             seg_o,
  output logic [LEN_W:0]   cnt_o,
  output logic [SJW_W-1:0] ext_o,
  output logic [SJW_W-1:0] cut_o,
  output logic             done_o,
  output logic             sample_o,
  output logic             rx_bit_o
);
  localparam int CW = LEN_W + 1;

  seg_e          seg_q;
  logic [CW-1:0] cnt_q;
  logic [SJW_W-1:0] ext_q, cut_q;
  logic          done_q, sample_q, bit_q;
  logic [CW-1:0] prop_end, ph1_end, ph2_end;

  assign prop_end = CW'(prop_len_i) - CW'(1);
  assign ph1_end  = CW'(ph1_len_i) + CW'(ext_n_i) - CW'(1);
  assign ph2_end  = CW'(ph2_len_i) - CW'(cut_n_i) - CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q    <= SEG_SYNC;
      cnt_q    <= '0;
      ext_q    <= '0;
      cut_q    <= '0;
      done_q   <= 1'b0;
      sample_q <= 1'b0;
      bit_q    <= 1'b1;
    end else begin
      sample_q <= 1'b0;
      if (tq_en_i) begin
        if (hard_i) begin
          seg_q  <= SEG_PROP;
          cnt_q  <= '0;
          ext_q  <= '0;
          cut_q  <= '0;
          done_q <= 1'b0;
        end else begin
          ext_q  <= ext_n_i;
          cut_q  <= cut_n_i;
          done_q <= done_n_i;
          case (seg_q)
            SEG_SYNC: begin
              seg_q <= SEG_PROP;
              cnt_q <= '0;
            end
            SEG_PROP: begin
              if (cnt_q >= prop_end) begin
                seg_q <= SEG_PH1;
                cnt_q <= '0;
              end else cnt_q <= cnt_q + CW'(1);
            end
            SEG_PH1: begin
              if (cnt_q >= ph1_end) begin
                seg_q    <= SEG_PH2;
                cnt_q    <= '0;
                sample_q <= 1'b1;
                bit_q    <= rx_sync_i;
              end else cnt_q <= cnt_q + CW'(1);
            end
            default: begin
              if (cnt_q >= ph2_end) begin
                seg_q  <= SEG_SYNC;
                cnt_q  <= '0;
                ext_q  <= '0;
                cut_q  <= '0;
                done_q <= 1'b0;
              end else cnt_q <= cnt_q + CW'(1);
            end
          endcase
        end
      end
    end
  end

  assign seg_o    = seg_q;
  assign cnt_o    = cnt_q;
  assign ext_o    = ext_q;
  assign cut_o    = cut_q;
  assign done_o   = done_q;
  assign sample_o = sample_q;
  assign rx_bit_o = bit_q;
endmodule

// File: rtl/can_bit_sync.sv
module can_bit_sync
  import can_bt_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int SJW_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tq_en_i,
  input  logic             rx_i,
  input  logic             idle_i,
  input  logic [LEN_W-1:0] prop_len_i,
  input  logic [LEN_W-1:0] ph1_len_i,
  input  logic [LEN_W-1:0] ph2_len_i,
  input  logic [SJW_W-1:0] sjw_i,
  output logic             sample_o,
  output logic             rx_bit_o,
  output logic             boundary_o
);
  localparam int CW = LEN_W + 1;

  logic             rx_sync_w, fall_w, hard_w, try_w;
  seg_e             seg_w;
  logic [CW-1:0]    cnt_w;
  logic [SJW_W-1:0] ext_q, cut_q, ext_n, cut_n;
  logic             done_q, done_n;

  can_bt_rx_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tq_en_i   (tq_en_i),
    .rx_i      (rx_i),
    .rx_sync_o (rx_sync_w),
    .fall_o    (fall_w)
  );

  assign hard_w = fall_w & idle_i;
  assign try_w  = fall_w & ~idle_i & rx_bit_o;

  can_bt_resync #(.LEN_W(LEN_W), .SJW_W(SJW_W)) u_resync (
    .seg_i      (seg_w),
    .cnt_i      (cnt_w),
    .prop_len_i (prop_len_i),
    .ph2_len_i  (ph2_len_i),
    .sjw_i      (sjw_i),
    .ext_i      (ext_q),
    .cut_i      (cut_q),
    .done_i     (done_q),
    .try_i      (try_w),
    .ext_o      (ext_n),
    .cut_o      (cut_n),
    .done_o     (done_n)
  );

  can_bt_seq #(.LEN_W(LEN_W), .SJW_W(SJW_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tq_en_i    (tq_en_i),
    .hard_i     (hard_w),
    .rx_sync_i  (rx_sync_w),
    .prop_len_i (prop_len_i),
    .ph1_len_i  (ph1_len_i),
    .ph2_len_i  (ph2_len_i),
    .ext_n_i    (ext_n),
    .cut_n_i    (cut_n),
    .done_n_i   (done_n),
    .seg_o      (seg_w),
    .cnt_o      (cnt_w),
    .ext_o      (ext_q),
    .cut_o      (cut_q),
    .done_o     (done_q),
    .sample_o   (sample_o),
    .rx_bit_o   (rx_bit_o)
  );

  assign boundary_o = (seg_w == SEG_SYNC);
endmodule

// File: rtl/can_bit_sync_chk.sv
module can_bit_sync_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tq_en_i,
  input logic idle_i,
  input logic fall_i,
  input logic sample_o,
  input logic rx_bit_o,
  input logic boundary_o
);
  logic       armed_q, hs_q;
  logic [1:0] smp_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      hs_q      <= 1'b0;
      smp_cnt_q <= '0;
    end else begin
      armed_q <= 1'b1;
      hs_q    <= tq_en_i & idle_i & fall_i;
      if (boundary_o || hs_q) smp_cnt_q <= '0;
      else if (sample_o && smp_cnt_q != 2'd3) smp_cnt_q <= smp_cnt_q + 2'd1;
    end
  end

  p_sample_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);

  p_no_overlap_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_o && boundary_o));

  p_once_per_bit_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_cnt_q < 2'd2);

  p_sample_on_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && sample_o) |-> $past(tq_en_i));

  p_hold_between_ticks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !$past(tq_en_i)) |-> ($stable(boundary_o) && $stable(rx_bit_o)));

  p_bit_with_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !$stable(rx_bit_o)) |-> sample_o);

  p_hard_sync_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && hs_q) |-> (!boundary_o && !sample_o));
endmodule

bind can_bit_sync can_bit_sync_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tq_en_i    (tq_en_i),
  .idle_i     (idle_i),
  .fall_i     (fall_w),
  .sample_o   (sample_o),
  .rx_bit_o   (rx_bit_o),
  .boundary_o (boundary_o)
);

// File: tb/tb_can_bit_sync.sv
module tb_can_bit_sync;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       tq_en = 1'b0, rx = 1'b1, idle = 1'b0;
  logic [3:0] prop = 4'd2, ph1 = 4'd3, ph2 = 4'd3;
  logic [2:0] sjw = 3'd1;
  logic       sample, rx_bit, boundary;

  can_bit_sync dut (
    .clk_i(clk), .rst_ni(rst_n), .tq_en_i(tq_en), .rx_i(rx), .idle_i(idle),
    .prop_len_i(prop), .ph1_len_i(ph1), .ph2_len_i(ph2), .sjw_i(sjw),
    .sample_o(sample), .rx_bit_o(rx_bit), .boundary_o(boundary)
  );

  int    n_cmp = 0, n_fail = 0;
  int    tq_div = 1, div_cnt = 0;
  string cur_req = "R1";

  // reference model: quantum index inside the bit, 0 = sync quantum
  bit m_d1, m_d2, m_prev, m_bit, m_smp, m_fall, m_lvl, m_done;
  int m_q, m_ext, m_cut, m_r;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_d1 = 1; m_d2 = 1; m_prev = 1; m_bit = 1; m_smp = 0;
      m_q = 0; m_ext = 0; m_cut = 0; m_done = 0;
    end else begin
      m_smp = 0;
      if (tq_en) begin
        m_fall = m_prev && !m_d2;
        m_lvl  = m_d2;
        m_prev = m_d2;
        if (m_fall && idle) begin
          m_q = 1; m_ext = 0; m_cut = 0; m_done = 0;
        end else begin
          if (m_fall && !idle && m_bit && !m_done) begin
            if (m_q >= 1 && m_q <= prop + ph1) begin
              m_ext = (m_q < sjw) ? m_q : int'(sjw);
              m_done = 1;
            end else if (m_q > prop + ph1) begin
              m_r = prop + ph1 + ph2 - m_q;
              if (m_r > 0) begin
                m_cut = (m_r < sjw) ? m_r : int'(sjw);
                m_done = 1;
              end
            end
          end
          if (m_q == prop + ph1 + m_ext) begin
            m_smp = 1; m_bit = m_lvl;
          end
          if (m_q >= prop + ph1 + m_ext + ph2 - m_cut) begin
            m_q = 0; m_ext = 0; m_cut = 0; m_done = 0;
          end else m_q++;
        end
      end
      m_d2 = m_d1;
      m_d1 = rx;
    end
  end

  task automatic compare();
    bit exp_b;
    exp_b = (m_q == 0);
    n_cmp++;
    if (sample !== m_smp || rx_bit !== m_bit || boundary !== exp_b) begin
      n_fail++;
      $display("FAIL %s t=%0t actual sample=%0b bit=%0b boundary=%0b expected sample=%0b bit=%0b boundary=%0b",
               cur_req, $time, sample, rx_bit, boundary, m_smp, m_bit, exp_b);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    compare();
    tq_en   = (div_cnt == 0);
    div_cnt = (div_cnt + 1 >= tq_div) ? 0 : div_cnt + 1;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic apply_cfg(int p, int a, int b, int s, int div);
    @(negedge clk);
    rst_n = 0; tq_en = 0; rx = 1; idle = 0;
    prop = 4'(p); ph1 = 4'(a); ph2 = 4'(b); sjw = 3'(s);
    tq_div = div; div_cnt = 0;
    run(2);
    rst_n = 1;
  endtask

  // random rx activity; pct = toggle chance per cycle, idle_mode 2 = random idle
  task automatic run_rand(int n, int pct, int idle_mode);
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(99) < pct) rx = ~rx;
      if (idle_mode == 2) begin
        if ($urandom_range(99) < 2) idle = ~idle;
      end else idle = idle_mode[0];
      cycle();
    end
  endtask

  task automatic all_tests();
    // R1: reset values
    cur_req = "R1";
    rst_n = 0;
    run(3);
    n_cmp++;
    if (boundary !== 1'b1 || sample !== 1'b0 || rx_bit !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 actual sample=%0b bit=%0b boundary=%0b expected 0 1 1", sample, rx_bit, boundary);
    end
    rst_n = 1;
    run(4);

    // R2: nominal bits, no edges
    cur_req = "R2";
    apply_cfg(2, 3, 3, 1, 1);
    run(80);
    apply_cfg(8, 8, 8, 4, 1);
    run(120);
    apply_cfg(1, 1, 2, 1, 1);
    run(40);

    // R4: sparse ticks
    cur_req = "R4";
    apply_cfg(3, 4, 5, 2, 3);
    run_rand(400, 3, 0);

    // R3: sampled value follows bus
    cur_req = "R3";
    apply_cfg(2, 2, 3, 2, 2);
    run_rand(800, 4, 0);

    // R5: hard sync while idle
    cur_req = "R5";
    apply_cfg(4, 5, 6, 1, 2);
    for (int k = 0; k < 30; k++) begin
      idle = 1; rx = 1;
      run(6 + k);
      rx = 0;
      run(5 + (k % 4));
      rx = 1;
      run(3);
    end

    // R6, R7, R8: resync across edge positions and jump widths
    cur_req = "R6";
    apply_cfg(3, 3, 3, 3, 1);
    run_rand(1500, 8, 0);
    cur_req = "R7";
    for (int s = 1; s <= 4; s++) begin
      apply_cfg(5, 6, 4, s, 2);
      run_rand(1500, 5, 0);
    end
    cur_req = "R8";
    for (int s = 1; s <= 4; s++) begin
      apply_cfg(2, 3, 8, s, 1);
      run_rand(1500, 6, 0);
    end

    // R9: gating by idle and by last sampled bit
    cur_req = "R9";
    apply_cfg(3, 4, 4, 2, 1);
    run_rand(3000, 10, 2);

    // R10: dense edges, several per bit
    cur_req = "R10";
    apply_cfg(4, 4, 5, 4, 1);
    run_rand(2000, 35, 0);

    // R11: long run mixing adjusted and plain bits
    cur_req = "R11";
    apply_cfg(6, 7, 7, 3, 2);
    run_rand(3000, 3, 0);

    // R12: mixed traffic, all modes
    cur_req = "R12";
    apply_cfg(1, 2, 2, 2, 1);
    run_rand(3000, 12, 2);
  endtask

  initial begin
    fork
      all_tests();
      begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL %s watchdog expired actual=hung expected=finished", cur_req);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end
endmodule